// File: doc/BRIEF.md
# Multi-Slot Conversion Sequence Controller

This controller decides which of sixteen conversion slots an analog converter works on next, and when a run of conversions stops. Each slot holds a control word with an input-channel select, a reference select and an end-of-run marker. The controller presents the active slot's fields to the converter, raises a one-cycle conversion request, and waits for the converter's completion strobe. When the completion strobe arrives it emits a write strobe tagged with the slot index, so that result storage outside this block can capture the result.

A two-bit mode picks one of four run shapes:
- 0: one slot converted once.
- 1: a run of slots that ends at a marked slot.
- 2: one slot converted again and again.
- 3: a run of slots repeated from the start slot.

In modes 1 to 3 a back-to-back bit decides what starts each conversion after the first. When the bit is clear, each conversion waits for a new trigger edge. When it is set, the next conversion starts as soon as the previous one completes. The trigger is a level input and only its rising edge counts.

The state machine has three states: `ST_IDLE`, `ST_CONV` (a request is out and completion is awaited) and `ST_WAIT` (the run is paused until the next trigger edge). The transitions are:
- launch: `ST_IDLE`→`ST_CONV`.
- chain: `ST_CONV`→`ST_CONV`, with back-to-back set.
- pause: `ST_CONV`→`ST_WAIT`, with back-to-back clear.
- resume: `ST_WAIT`→`ST_CONV`, on a trigger edge.
- finish: `ST_CONV`→`ST_IDLE`, at the end of the run.
- abandon: `ST_WAIT`→`ST_IDLE`, when enable is low.

Top module: `conv_seq_ctrl`

## Requirements
- R1: After reset, `busy`, `conv_req` and `wr_strobe` are 0 and `cur_slot` is 0.
- R2: In mode 0, a trigger rising edge while `enable` is high selects `start_slot`. One cycle later `conv_req` pulses. After `conv_done`, the controller returns to idle with `busy` low.
- R3: In mode 1, slots are converted in ascending order from `start_slot`. The run ends after the slot whose `slot_eos` bit is 1.
- R4: In mode 2 the same slot is converted again and again. In mode 3, after the end-marked slot, the run goes back to `start_slot`.
- R5: During a run, slot 15 with no end marker is followed by slot 0.
- R6: While a slot is active, `cur_chan` equals bits [4s+3:4s] of `slot_chan` and `cur_ref` equals bits [3s+2:3s] of `slot_ref`, where s is `cur_slot`.
- R7: With `multi`=1 in modes 1 to 3, the next `conv_req` follows a `conv_done` with no new trigger.
- R8: With `multi`=0 in mode 1, after each non-final conversion the controller keeps `busy` high and issues no `conv_req` until a new trigger rising edge.
- R9: A trigger edge while `enable` is low starts nothing.
- R10: In a repeat mode, clearing `enable` lets the current conversion (mode 2) or the current pass up to the end-marked slot (mode 3) complete, and then the controller goes idle.
- R11: A trigger edge that arrives in the same cycle that `enable` rises starts a run.
- R12: `wr_strobe` pulses for one cycle, with `wr_slot` equal to the completed slot, in the cycle after `conv_done` is seen during a conversion. A `conv_done` seen while idle produces no `wr_strobe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Conversion enable |
| trig | input | 1 | Start trigger level; its rising edge counts |
| conv_done | input | 1 | Conversion-complete strobe from the converter |
| mode | input | 2 | Run shape: 0 single, 1 run, 2 repeat single, 3 repeat run |
| multi | input | 1 | Back-to-back conversions after the first trigger |
| start_slot | input | 4 | First slot of a run |
| slot_eos | input | 16 | End-of-run marker per slot |
| slot_chan | input | 64 | Four-bit channel select per slot, slot s at [4s+3:4s] |
| slot_ref | input | 48 | Three-bit reference select per slot, slot s at [3s+2:3s] |
| cur_slot | output | 4 | Active slot index |
| cur_chan | output | 4 | Channel select of the active slot |
| cur_ref | output | 3 | Reference select of the active slot |
| conv_req | output | 1 | One-cycle start-conversion request |
| busy | output | 1 | High while a conversion or run is in progress |
| wr_strobe | output | 1 | Result write strobe |
| wr_slot | output | 4 | Slot index for the result write |

## Verification
The hardest case to reach from the ports is the wrap from slot 15 to slot 0. It can only happen in the middle of a run whose end marker lies below its start slot. The bench reaches it with a run starting at slot 14 and the marker on slot 1. A second hard case is clearing `enable` in the middle of a repeat pass: the bench drops `enable` while a non-final slot is converting and checks that the remaining slot of the pass still converts before the controller goes idle.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_t;

    // mode[0]: run of slots, mode[1]: repeat
    localparam int MODE_RUN_BIT = 0;
    localparam int MODE_REP_BIT = 1;
endpackage

// File: rtl/seq_trig_edge.sv
module seq_trig_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic rise
);
    logic level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_in;
    end

    assign rise = level_in & ~level_q;
endmodule

// File: rtl/seq_slot_field.sv
module seq_slot_field #(
    parameter int NUM_SLOTS = 16,
    parameter int FIELD_W   = 4,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS*FIELD_W-1:0] packed_in,
    input  logic [SLOT_W-1:0]            sel,
    output logic [FIELD_W-1:0]           field
);
    logic [FIELD_W-1:0] unpacked [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_unpack
        assign unpacked[g] = packed_in[g*FIELD_W +: FIELD_W];
    end

    assign field = unpacked[sel];
endmodule

// File: rtl/seq_slot_step.sv
module seq_slot_step #(
    parameter int NUM_SLOTS = 16,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic [SLOT_W-1:0] slot,
    output logic [SLOT_W-1:0] next_slot
);
    localparam logic [SLOT_W-1:0] TOP = SLOT_W'(NUM_SLOTS - 1);

    always_comb begin
        if (slot == TOP) next_slot = '0;
        else             next_slot = slot + 1'b1;
    end
endmodule

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl
    import conv_seq_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int CH_W      = 4,
    parameter int REF_W     = 3,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enable,
    input  logic                       trig,
    input  logic                       conv_done,
    input  logic [1:0]                 mode,
    input  logic                       multi,
    input  logic [SLOT_W-1:0]          start_slot,
    input  logic [NUM_SLOTS-1:0]       slot_eos,
    input  logic [NUM_SLOTS*CH_W-1:0]  slot_chan,
    input  logic [NUM_SLOTS*REF_W-1:0] slot_ref,
    output logic [SLOT_W-1:0]          cur_slot,
    output logic [CH_W-1:0]            cur_chan,
    output logic [REF_W-1:0]           cur_ref,
    output logic                       conv_req,
    output logic                       busy,
    output logic                       wr_strobe,
    output logic [SLOT_W-1:0]          wr_slot
);
    seq_state_t        state, nstate;
    logic [SLOT_W-1:0] slot, nslot, step_slot;
    logic              trig_rise, issue, wr_now, last_here;

    seq_trig_edge u_edge (
        .clk(clk), .rst_n(rst_n), .level_in(trig), .rise(trig_rise)
    );

    seq_slot_step #(.NUM_SLOTS(NUM_SLOTS)) u_step (
        .slot(slot), .next_slot(step_slot)
    );

    seq_slot_field #(.NUM_SLOTS(NUM_SLOTS), .FIELD_W(CH_W)) u_chan (
        .packed_in(slot_chan), .sel(slot), .field(cur_chan)
    );

    seq_slot_field #(.NUM_SLOTS(NUM_SLOTS), .FIELD_W(REF_W)) u_ref (
        .packed_in(slot_ref), .sel(slot), .field(cur_ref)
    );

    // a non-run mode treats every conversion as the last of its run
    assign last_here = mode[MODE_RUN_BIT] ? slot_eos[slot] : 1'b1;

    always_comb begin
        nstate = state;
        nslot  = slot;
        issue  = 1'b0;
        wr_now = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (enable && trig_rise) begin
                    nslot  = start_slot;
                    nstate = ST_CONV;
                    issue  = 1'b1;
                end
            end
            ST_CONV: begin
                if (conv_done) begin
                    wr_now = 1'b1;
                    if ((!mode[MODE_REP_BIT] && last_here) ||
                        (mode[MODE_REP_BIT] && last_here && !enable)) begin
                        nstate = ST_IDLE;
                    end else begin
                        if (!last_here)                nslot = step_slot;
                        else if (mode[MODE_RUN_BIT])   nslot = start_slot;
                        else                           nslot = slot;
                        if (multi) begin
                            nstate = ST_CONV;
                            issue  = 1'b1;
                        end else begin
                            nstate = ST_WAIT;
                        end
                    end
                end
            end
            ST_WAIT: begin
                if (!enable) begin
                    nstate = ST_IDLE;
                end else if (trig_rise) begin
                    nstate = ST_CONV;
                    issue  = 1'b1;
                end
            end
            default: nstate = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            slot  <= '0;
        end else begin
            state <= nstate;
            slot  <= nslot;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conv_req  <= 1'b0;
            wr_strobe <= 1'b0;
            wr_slot   <= '0;
        end else begin
            conv_req  <= issue;
            wr_strobe <= wr_now;
            if (wr_now) wr_slot <= slot;
        end
    end

    assign cur_slot = slot;
    assign busy     = (state != ST_IDLE);

    a_r2_single_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV && conv_done && mode == 2'd0) |=> (state == ST_IDLE));

    a_r5_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV && conv_done && mode[MODE_RUN_BIT] &&
         slot == SLOT_W'(NUM_SLOTS - 1) && !slot_eos[NUM_SLOTS-1]) |=> (slot == '0));

    a_r9_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !enable) |=> (state == ST_IDLE && !conv_req));

    a_r12_write_follows_done: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> ($past(conv_done) && $past(state) == ST_CONV));

    a_r7_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> (state == ST_CONV));
endmodule

// File: tb/sim_conv_seq_ctrl.sv
module sim_conv_seq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0, trig = 1'b0, conv_done = 1'b0, multi = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [3:0]  start_slot = 4'd0;
    logic [15:0] slot_eos = 16'd0;
    logic [63:0] slot_chan;
    logic [47:0] slot_ref;
    logic [3:0]  cur_slot, cur_chan, wr_slot;
    logic [2:0]  cur_ref;
    logic        conv_req, busy, wr_strobe;
    int          checks = 0, errors = 0;
    bit          done_flag = 1'b0;

    always #2.5 clk = ~clk;

    conv_seq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .trig(trig), .conv_done(conv_done),
        .mode(mode), .multi(multi), .start_slot(start_slot), .slot_eos(slot_eos),
        .slot_chan(slot_chan), .slot_ref(slot_ref), .cur_slot(cur_slot),
        .cur_chan(cur_chan), .cur_ref(cur_ref), .conv_req(conv_req), .busy(busy),
        .wr_strobe(wr_strobe), .wr_slot(wr_slot)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_trig();
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    // wait for a request, check slot and fields, complete it, check the write
    task automatic conv_step(input int exp_slot, input bit drop_en, input string req);
        int waited = 0;
        while (!conv_req && waited < 20) begin
            @(negedge clk);
            waited++;
        end
        chk(conv_req, req, conv_req, 1);
        chk(cur_slot == 4'(exp_slot), req, cur_slot, exp_slot);
        chk(cur_chan == 4'(15 - exp_slot), "R6", cur_chan, 15 - exp_slot);
        chk(cur_ref == 3'(exp_slot % 8), "R6", cur_ref, exp_slot % 8);
        if (drop_en) enable = 1'b0;
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        chk(wr_strobe && wr_slot == 4'(exp_slot), "R12", wr_slot, exp_slot);
    endtask

    task automatic quiet(input int cycles, input bit exp_busy, input string req);
        bit seen = 1'b0;
        bit b_ok = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (conv_req) seen = 1'b1;
            if (busy != exp_busy) b_ok = 1'b0;
        end
        chk(!seen, req, seen, 0);
        chk(b_ok, req, busy, exp_busy);
    endtask

    task automatic t_reset();
        chk(!busy && !conv_req && !wr_strobe, "R1", {busy, conv_req, wr_strobe}, 0);
        chk(cur_slot == 4'd0, "R1", cur_slot, 0);
    endtask

    task automatic t_single();
        mode = 2'd0; multi = 1'b0; start_slot = 4'd5; enable = 1'b1;
        @(negedge clk);
        pulse_trig();
        conv_step(5, 1'b0, "R2");
        chk(!busy, "R2", busy, 0);
        quiet(4, 1'b0, "R2");
    endtask

    task automatic t_disabled();
        enable = 1'b0; mode = 2'd1; multi = 1'b1;
        @(negedge clk);
        pulse_trig();
        quiet(8, 1'b0, "R9");
    endtask

    task automatic t_seq_multi();
        mode = 2'd1; multi = 1'b1; start_slot = 4'd3; slot_eos = 16'h0020; enable = 1'b1;
        @(negedge clk);
        pulse_trig();
        conv_step(3, 1'b0, "R3");
        conv_step(4, 1'b0, "R7");
        conv_step(5, 1'b0, "R3");
        chk(!busy, "R3", busy, 0);
    endtask

    task automatic t_seq_step();
        mode = 2'd1; multi = 1'b0; start_slot = 4'd6; slot_eos = 16'h0080; enable = 1'b1;
        @(negedge clk);
        pulse_trig();
        conv_step(6, 1'b0, "R8");
        quiet(5, 1'b1, "R8");
        pulse_trig();
        conv_step(7, 1'b0, "R8");
        chk(!busy, "R8", busy, 0);
    endtask

    task automatic t_wrap();
        mode = 2'd1; multi = 1'b1; start_slot = 4'd14; slot_eos = 16'h0002; enable = 1'b1;
        @(negedge clk);
        pulse_trig();
        conv_step(14, 1'b0, "R5");
        conv_step(15, 1'b0, "R5");
        conv_step(0, 1'b0, "R5");
        conv_step(1, 1'b0, "R5");
        chk(!busy, "R5", busy, 0);
    endtask

    task automatic t_rep_single();
        mode = 2'd2; multi = 1'b1; start_slot = 4'd9; slot_eos = 16'h0000; enable = 1'b1;
        @(negedge clk);
        pulse_trig();
        conv_step(9, 1'b0, "R4");
        conv_step(9, 1'b0, "R4");
        conv_step(9, 1'b1, "R10");
        chk(!busy, "R10", busy, 0);
        quiet(5, 1'b0, "R10");
    endtask

    task automatic t_rep_seq();
        mode = 2'd3; multi = 1'b1; start_slot = 4'd2; slot_eos = 16'h0008; enable = 1'b1;
        @(negedge clk);
        pulse_trig();
        conv_step(2, 1'b0, "R4");
        conv_step(3, 1'b0, "R4");
        conv_step(2, 1'b1, "R4");
        chk(busy, "R10", busy, 1);
        conv_step(3, 1'b0, "R10");
        chk(!busy, "R10", busy, 0);
        quiet(5, 1'b0, "R10");
    endtask

    task automatic t_same_cycle();
        mode = 2'd0; multi = 1'b0; start_slot = 4'd12; enable = 1'b0;
        @(negedge clk);
        enable = 1'b1;
        pulse_trig();
        conv_step(12, 1'b0, "R11");
        chk(!busy, "R11", busy, 0);
    endtask

    task automatic t_idle_done();
        bit seen = 1'b0;
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        for (int i = 0; i < 3; i++) begin
            if (wr_strobe) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen && !busy, "R12", seen, 0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            slot_chan[i*4 +: 4] = 4'(15 - i);
            slot_ref[i*3 +: 3]  = 3'(i % 8);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_disabled();
        t_seq_multi();
        t_seq_step();
        t_wrap();
        t_rep_single();
        t_rep_seq();
        t_same_cycle();
        t_idle_done();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule